// File: doc/BRIEF.md
# Synchronous Peripheral Cycle Bridge

This block runs the old style of synchronous peripheral bus cycle on behalf of a processor that has no such cycle of its own, or that runs from a clock unrelated to the motherboard. It is clocked by the motherboard clock (about 7 MHz). From reset it drives a free-running, divided peripheral clock `eClk`. A peripheral cycle begins when the motherboard answers a processor bus cycle by pulling the valid-peripheral-address request `vpaN` low while the processor holds its address strobe `asN` low.

The bridge does not act on the request at once. It waits for the next point where `eClk` goes low, and on that edge it drives the valid-memory-address strobe `vmaN` low. It keeps `vmaN` low through the whole low phase and the high phase that follows. One clock before `eClk` falls again, it drives the data acknowledge `dtackN` low toward the processor, so the processor latches read data on the falling edge of `eClk`. Both strobes stay low until the processor raises `asN`. If the processor raises `asN` before the acknowledge is given, the bridge drops the request and never acknowledges it. `asN` and `vpaN` are taken as already synchronous to `clk`.

Top module: `sync_periph_bridge`

## Requirements
- R1: `eClk` has a period of E_LOW+E_HIGH clocks (defaults 6 and 4). It is low for E_LOW clocks and then high for E_HIGH clocks. It starts its low phase at reset release and keeps running whether or not a request is pending.
- R2: While `rstN` is low, `eClk` is 0 and `vmaN` and `dtackN` are 1.
- R3: A request is accepted on a clock edge that samples both `asN` and `vpaN` at 0 while no request is pending. `vmaN` then goes to 0 on the first later edge at which `eClk` changes from 1 to 0, and never at any other point.
- R4: With `vmaN` at 0 and `asN` still at 0, `dtackN` goes to 0 on the edge that starts the last DTACK_LEAD clocks (default 1) of the `eClk` high phase. `eClk` therefore falls DTACK_LEAD clocks after `dtackN` falls. `dtackN` is never 0 while `vmaN` is 1.
- R5: On the edge after one that samples `asN` at 1, `vmaN` and `dtackN` are both 1.
- R6: If `asN` returns to 1 before the acknowledge edge of R4, the request is dropped. `dtackN` stays at 1 for that request, and no strobe is driven until a new request is accepted.
- R7: `vpaN` at 0 while `asN` is 1 is ignored: `vmaN` stays at 1.
- R8: `vpaN` is sampled only when a request is accepted. If `vpaN` returns to 1 afterwards, the cycle is not cancelled and `vmaN` and `dtackN` follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Motherboard clock |
| rstN | input | 1 | Asynchronous reset, active low |
| asN | input | 1 | Processor address strobe, active low |
| vpaN | input | 1 | Valid peripheral address request from motherboard, active low |
| eClk | output | 1 | Free-running peripheral clock |
| vmaN | output | 1 | Valid memory address toward motherboard, active low |
| dtackN | output | 1 | Data acknowledge toward processor, active low |

## Verification
The main function is tried with requests that arrive at every position within the `eClk` period. These show whether `vmaN` waits for the next falling edge of `eClk` or starts in the middle of a phase. Random strobe lengths cover three cases: `asN` released before `vmaN`, released between `vmaN` and `dtackN`, and held past the acknowledge. These separate an aborted cycle from a completed one and check that release always takes one clock. Further patterns cover `vpaN` asserted without `asN`, and `vpaN` withdrawn right after acceptance. They show that the request is qualified by the strobe and latched only once.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_VMA  = 2'd2,
    ST_ACK  = 2'd3
  } busState_t;

  typedef struct packed {
    logic setVma;
    logic setDtack;
    logic clrBus;
  } busStrobes_t;

endpackage

// File: rtl/spb_datapath.sv
module spb_datapath
  import spb_pkg::*;
#(
  parameter int E_LOW      = 6,
  parameter int E_HIGH     = 4,
  parameter int DTACK_LEAD = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrobes_t stb,
  output logic        eLowNext,
  output logic        dtackNext,
  output logic        eClk,
  output logic        vmaN,
  output logic        dtackN
);

  localparam int PERIOD  = E_LOW + E_HIGH;
  localparam int PW      = $clog2(PERIOD);
  localparam int ACK_AT  = PERIOD - 1 - DTACK_LEAD;

  logic [PW-1:0] phase;
  logic [PW-1:0] phaseNext;

  always_comb begin
    if (phase == PW'(PERIOD - 1)) phaseNext = '0;
    else                          phaseNext = phase + 1'b1;
  end

  assign eLowNext  = (phase == PW'(PERIOD - 1));
  assign dtackNext = (phase == PW'(ACK_AT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      eClk  <= 1'b0;
    end else begin
      phase <= phaseNext;
      eClk  <= (phaseNext >= PW'(E_LOW));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vmaN   <= 1'b1;
      dtackN <= 1'b1;
    end else if (stb.clrBus) begin
      vmaN   <= 1'b1;
      dtackN <= 1'b1;
    end else begin
      if (stb.setVma)   vmaN   <= 1'b0;
      if (stb.setDtack) dtackN <= 1'b0;
    end
  end

endmodule

// File: rtl/spb_control.sv
module spb_control
  import spb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        asN,
  input  logic        vpaN,
  input  logic        eLowNext,
  input  logic        dtackNext,
  output busStrobes_t stb
);

  busState_t state;
  busState_t stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (!asN && !vpaN) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (asN) begin
          stateNext = ST_IDLE;
        end else if (eLowNext) begin
          stateNext  = ST_VMA;
          stb.setVma = 1'b1;
        end
      end
      ST_VMA: begin
        if (asN) begin
          stateNext  = ST_IDLE;
          stb.clrBus = 1'b1;
        end else if (dtackNext) begin
          stateNext    = ST_ACK;
          stb.setDtack = 1'b1;
        end
      end
      ST_ACK: begin
        if (asN) begin
          stateNext  = ST_IDLE;
          stb.clrBus = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sync_periph_bridge.sv
module sync_periph_bridge
  import spb_pkg::*;
#(
  parameter int E_LOW      = 6,
  parameter int E_HIGH     = 4,
  parameter int DTACK_LEAD = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asN,
  input  logic vpaN,
  output logic eClk,
  output logic vmaN,
  output logic dtackN
);

  busStrobes_t stb;
  logic        eLowNext;
  logic        dtackNext;

  spb_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .asN       (asN),
    .vpaN      (vpaN),
    .eLowNext  (eLowNext),
    .dtackNext (dtackNext),
    .stb       (stb)
  );

  spb_datapath #(
    .E_LOW      (E_LOW),
    .E_HIGH     (E_HIGH),
    .DTACK_LEAD (DTACK_LEAD)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .eLowNext  (eLowNext),
    .dtackNext (dtackNext),
    .eClk      (eClk),
    .vmaN      (vmaN),
    .dtackN    (dtackN)
  );

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int E_LOW  = 6,
  parameter int E_HIGH = 4
) (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic eClk,
  input logic vmaN,
  input logic dtackN
);

  localparam int RW = $clog2(E_LOW + E_HIGH + 1) + 1;

  logic          prevE;
  logic [RW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevE  <= 1'b0;
      runLen <= '0;
    end else begin
      prevE  <= eClk;
      if (eClk != prevE) runLen <= RW'(1);
      else               runLen <= runLen + 1'b1;
    end
  end

  a_r1_e_phase_len: assert property (@(posedge clk) disable iff (!rstN)
    (eClk != prevE) |-> (prevE ? (runLen == RW'(E_HIGH)) : (runLen == RW'(E_LOW))));

  a_r3_vma_at_e_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vmaN) |-> (!eClk && $past(eClk)));

  a_r4_dtack_needs_vma: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |-> !vmaN);

  a_r4_dtack_in_e_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> eClk);

  a_r5_release_on_as: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> (vmaN && dtackN));

endmodule

bind sync_periph_bridge spb_checker #(
  .E_LOW  (E_LOW),
  .E_HIGH (E_HIGH)
) i_spb_checker (
  .clk    (clk),
  .rstN   (rstN),
  .asN    (asN),
  .eClk   (eClk),
  .vmaN   (vmaN),
  .dtackN (dtackN)
);

// File: tb/test_sync_periph_bridge.sv
module test_sync_periph_bridge;

  localparam int CLK_PERIOD = 140;
  localparam int E_LOW      = 6;
  localparam int E_HIGH     = 4;
  localparam int LEAD       = 1;
  localparam int PERIOD     = E_LOW + E_HIGH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1;
  logic vpaN = 1'b1;
  logic eClk, vmaN, dtackN;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference state, built from the requirements
  int  refPhase = 0;
  int  refMode = 0;   // 0 idle, 1 accepted, 2 vma driven, 3 acknowledged
  bit  refVmaN = 1;
  bit  refDtackN = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_periph_bridge #(.E_LOW(E_LOW), .E_HIGH(E_HIGH), .DTACK_LEAD(LEAD)) i_sync_periph_bridge (
    .clk(clk), .rstN(rstN), .asN(asN), .vpaN(vpaN),
    .eClk(eClk), .vmaN(vmaN), .dtackN(dtackN)
  );

  function automatic bit expE(int ph);
    return ph >= E_LOW;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic refStep();
    int nextPh;
    nextPh = (refPhase + 1) % PERIOD;
    if (!rstN) begin
      refPhase = 0; refMode = 0; refVmaN = 1; refDtackN = 1;
      return;
    end
    if (asN) begin
      refMode = 0; refVmaN = 1; refDtackN = 1;            // R5, R6
    end else begin
      case (refMode)
        0: if (!vpaN) refMode = 1;                         // R3, R7
        1: if (nextPh == 0) begin refMode = 2; refVmaN = 0; end
        2: if (nextPh == PERIOD - LEAD) begin refMode = 3; refDtackN = 0; end
        default: ;
      endcase
    end
    refPhase = nextPh;
  endtask

  // one clock: reference follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    refStep();
    @(negedge clk);
    cycles++;
    check("R1", "eClk", int'(eClk), int'(expE(refPhase)));
    check("R3", "vmaN", int'(vmaN), int'(refVmaN));
    check("R4", "dtackN", int'(dtackN), int'(refDtackN));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    bit prevE;
    bit sawDtack;
    int waitCnt;
    void'($urandom(32'd4242));

    // R2: reset values
    repeat (3) @(negedge clk);
    check("R2", "eClk in reset", int'(eClk), 0);
    check("R2", "vmaN in reset", int'(vmaN), 1);
    check("R2", "dtackN in reset", int'(dtackN), 1);
    rstN = 1'b1;
    refPhase = 0;

    // R1: free running with no request, count phase lengths
    for (int i = 0; i < 3 * PERIOD; i++) tick();

    // R3/R4/R5: full directed cycle
    asN = 0; vpaN = 0;
    waitCnt = 0; prevE = eClk;
    while (vmaN && waitCnt < 3 * PERIOD) begin prevE = eClk; tick(); waitCnt++; end
    check("R3", "eClk fell with vmaN", int'(prevE && !eClk), 1);
    waitCnt = 0;
    while (dtackN && waitCnt < 3 * PERIOD) begin tick(); waitCnt++; end
    check("R4", "eClk high at dtackN", int'(eClk), 1);
    tick();
    check("R4", "eClk falls after lead", int'(eClk), 0);
    tick();
    asN = 1; vpaN = 1;
    tick();
    check("R5", "vmaN released", int'(vmaN), 1);
    check("R5", "dtackN released", int'(dtackN), 1);

    // R6: abort after vmaN, before acknowledge
    asN = 0; vpaN = 0;
    waitCnt = 0;
    while (vmaN && waitCnt < 3 * PERIOD) begin tick(); waitCnt++; end
    tick();
    asN = 1; vpaN = 1;
    sawDtack = 0;
    for (int i = 0; i < PERIOD; i++) begin tick(); if (!dtackN) sawDtack = 1; end
    check("R6", "dtackN after abort", int'(sawDtack), 0);
    check("R6", "vmaN after abort", int'(vmaN), 1);

    // R7: vpaN without asN
    vpaN = 0;
    for (int i = 0; i < 2 * PERIOD; i++) begin
      tick();
      check("R7", "vmaN with asN high", int'(vmaN), 1);
    end
    vpaN = 1;

    // R8: vpaN withdrawn just after acceptance
    asN = 0; vpaN = 0;
    tick();
    vpaN = 1;
    waitCnt = 0;
    while (dtackN && waitCnt < 3 * PERIOD) begin tick(); waitCnt++; end
    check("R8", "dtackN despite vpaN release", int'(dtackN), 0);
    check("R8", "vmaN despite vpaN release", int'(vmaN), 0);
    asN = 1;
    tick();

    // random bus cycles of varied length and request shape
    for (int t = 0; t < 400; t++) begin
      int gap, len;
      gap = $urandom_range(0, 4);
      for (int i = 0; i < gap; i++) begin
        vpaN = $urandom_range(0, 1);
        tick();
      end
      asN = 0;
      vpaN = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      len = $urandom_range(0, 34);
      for (int i = 0; i < len; i++) begin
        tick();
        if ($urandom_range(0, 7) == 0) vpaN = ~vpaN;
      end
      asN = 1; vpaN = 1;
      tick();
    end

    done = 1;
    finishRun();
  end

endmodule